// File: doc/BRIEF.md
# 16-bit ALU with Condition Flags

This block is the arithmetic and logic stage of a small integer core. It takes two 16-bit operands and a 4-bit operation code. It returns the 16-bit result in the same cycle, combinationally. It also keeps a 4-bit condition register holding zero, negative, carry and overflow.

Each operation has its own update mask, so an operation writes only the flags it defines and the other flags keep their value. Carry-consuming operations read the registered carry flag. These are add with carry, subtract with borrow and the two rotates.

A separate add-immediate input makes the unit perform an addition that writes all four flags, whatever code is on the operation select. The caller sign-extends the immediate onto the second operand. The flag register has a synchronous reset and an update enable.

Top module: `alu16_core`

## Requirements
- R1: The flag register is `flags_q` with bit 0 = Z, bit 1 = N, bit 2 = C, bit 3 = O. A synchronous reset clears all four bits on the next rising edge, and reset takes priority over the update enable.
- R2: When `flag_we` is low, no flag changes at the clock edge. `result` still reflects the selected operation.
- R3: Codes 0 (and), 1 (or), 6 (xor) and 7 (not of operand A) produce the bitwise result. They set N to result bit 15 and Z to (result == 0), and leave C and O unchanged.
- R4: Code 2 shifts operand A left by one, and code 3 shifts it right by one, filling the vacated bit with 0. C receives the bit shifted out, N and Z follow the result, and O is unchanged.
- R5: Code 4 (A+B) and code 5 (A−B) ignore the carry flag and give the result modulo 2^16. C is the carry out for add and the borrow for subtract (A < B unsigned). O is set on signed overflow, and N and Z follow the result.
- R6: Code 8 computes A+B+C and code 9 computes A−B−C, using the registered carry flag. C is the carry out or the borrow (A < B+C). O, N and Z are as in R5.
- R7: Code 10 rotates A left through the carry, so the old C enters bit 0. Code 11 rotates right, so the old C enters bit 15. Both update only N and Z, so C and O keep their value.
- R8: Codes 12 to 15 drive `result` to zero and leave all flags unchanged, even with `flag_we` high.
- R9: With `addi_mode` high, the unit computes A+B regardless of `op_sel`, with carry ignored. It updates all four flags as in R5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| flag_we | input | 1 | Flag update enable |
| addi_mode | input | 1 | Forces addition with all four flags updated |
| op_sel | input | 4 | Operation code |
| opnd_a | input | 16 | Operand A |
| opnd_b | input | 16 | Operand B (sign-extended immediate in add-immediate use) |
| result | output | 16 | Combinational result |
| flags_q | output | 4 | Registered flags {O, C, N, Z} |

## Verification
The vector table runs in order, so each entry starts from the flags the previous entry left behind. This lets the carry fed into add-with-carry, subtract-with-borrow and the rotates come from real earlier results. Operand pairs are chosen to separate the cases:
- carry out with no signed overflow,
- signed overflow with no carry,
- both at once,
- a borrow from a chain of subtractions,
- rotations whose outcome differs depending on the incoming carry.

Logic operations run after overflow or carry has been set, which shows those flags are held rather than cleared. Directed cases then cover:
- reset overriding an enabled update,
- unused codes,
- plain addition run while carry is set, which shows the carry is ignored.

// File: rtl/alu16_pkg.sv
package alu16_pkg;

  localparam int FLAG_N_BITS = 4;
  localparam int FLG_Z = 0;
  localparam int FLG_N = 1;
  localparam int FLG_C = 2;
  localparam int FLG_O = 3;

  typedef logic [FLAG_N_BITS-1:0] flag_vec_t;

  typedef enum logic [3:0] {
    OP_AND = 4'd0,
    OP_OR  = 4'd1,
    OP_SHL = 4'd2,
    OP_SHR = 4'd3,
    OP_ADD = 4'd4,
    OP_SUB = 4'd5,
    OP_XOR = 4'd6,
    OP_NOT = 4'd7,
    OP_ADC = 4'd8,
    OP_SBC = 4'd9,
    OP_ROL = 4'd10,
    OP_ROR = 4'd11
  } alu_op_e;

  localparam flag_vec_t MASK_NZ   = flag_vec_t'((1 << FLG_Z) | (1 << FLG_N));
  localparam flag_vec_t MASK_CNZ  = flag_vec_t'((1 << FLG_Z) | (1 << FLG_N) | (1 << FLG_C));
  localparam flag_vec_t MASK_ALL  = '1;
  localparam flag_vec_t MASK_NONE = '0;

endpackage

// File: rtl/alu16_mask_dec.sv
module alu16_mask_dec
  import alu16_pkg::*;
(
  input  logic [3:0] op_sel,
  input  logic       addi_mode,
  output logic [3:0] eff_op,
  output flag_vec_t  upd_mask,
  output logic       op_valid
);

  always_comb begin
    eff_op = addi_mode ? OP_ADD : op_sel;
  end

  always_comb begin
    op_valid = 1'b1;
    case (eff_op)
      OP_AND, OP_OR, OP_XOR, OP_NOT: upd_mask = MASK_NZ;
      OP_ROL, OP_ROR:                upd_mask = MASK_NZ;
      OP_SHL, OP_SHR:                upd_mask = MASK_CNZ;
      OP_ADD, OP_SUB, OP_ADC, OP_SBC: upd_mask = MASK_ALL;
      default: begin
        upd_mask = MASK_NONE;
        op_valid = 1'b0;
      end
    endcase
  end

endmodule

// File: rtl/alu16_datapath.sv
module alu16_datapath
  import alu16_pkg::*;
#(
  parameter int W = 16
) (
  input  logic [3:0]   eff_op,
  input  logic [W-1:0] opnd_a,
  input  logic [W-1:0] opnd_b,
  input  logic         carry_in,
  output logic [W-1:0] result,
  output flag_vec_t    nxt_flags
);

  localparam int MSB = W - 1;

  // Returns {carry_out, sum}
  function automatic logic [W:0] add_ext(input logic [W-1:0] a, input logic [W-1:0] b,
                                         input logic cin);
    add_ext = {1'b0, a} + {1'b0, b} + {{W{1'b0}}, cin};
  endfunction

  // Returns {borrow, difference}; bit W is set when a < b + bin
  function automatic logic [W:0] sub_ext(input logic [W-1:0] a, input logic [W-1:0] b,
                                         input logic bin);
    sub_ext = {1'b0, a} - {1'b0, b} - {{W{1'b0}}, bin};
  endfunction

  function automatic logic add_ovf(input logic sa, input logic sb, input logic sr);
    add_ovf = (sa == sb) && (sr != sa);
  endfunction

  function automatic logic sub_ovf(input logic sa, input logic sb, input logic sr);
    sub_ovf = (sa != sb) && (sr != sa);
  endfunction

  logic [W:0] arith_w;
  logic       c_new;
  logic       o_new;

  always_comb begin
    result  = '0;
    arith_w = '0;
    c_new   = carry_in;
    o_new   = 1'b0;
    case (eff_op)
      OP_AND: result = opnd_a & opnd_b;
      OP_OR:  result = opnd_a | opnd_b;
      OP_XOR: result = opnd_a ^ opnd_b;
      OP_NOT: result = ~opnd_a;
      OP_SHL: begin
        result = {opnd_a[MSB-1:0], 1'b0};
        c_new  = opnd_a[MSB];
      end
      OP_SHR: begin
        result = {1'b0, opnd_a[MSB:1]};
        c_new  = opnd_a[0];
      end
      OP_ROL: result = {opnd_a[MSB-1:0], carry_in};
      OP_ROR: result = {carry_in, opnd_a[MSB:1]};
      OP_ADD, OP_ADC: begin
        arith_w = add_ext(opnd_a, opnd_b, (eff_op == OP_ADC) ? carry_in : 1'b0);
        result  = arith_w[MSB:0];
        c_new   = arith_w[W];
        o_new   = add_ovf(opnd_a[MSB], opnd_b[MSB], arith_w[MSB]);
      end
      OP_SUB, OP_SBC: begin
        arith_w = sub_ext(opnd_a, opnd_b, (eff_op == OP_SBC) ? carry_in : 1'b0);
        result  = arith_w[MSB:0];
        c_new   = arith_w[W];
        o_new   = sub_ovf(opnd_a[MSB], opnd_b[MSB], arith_w[MSB]);
      end
      default: result = '0;
    endcase
  end

  always_comb begin
    nxt_flags        = '0;
    nxt_flags[FLG_Z] = (result == '0);
    nxt_flags[FLG_N] = result[MSB];
    nxt_flags[FLG_C] = c_new;
    nxt_flags[FLG_O] = o_new;
  end

endmodule

// File: rtl/alu16_flag_reg.sv
module alu16_flag_reg
  import alu16_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      flag_we,
  input  flag_vec_t upd_mask,
  input  flag_vec_t nxt_flags,
  output flag_vec_t flags_q
);

  for (genvar g = 0; g < FLAG_N_BITS; g++) begin : g_flag
    always_ff @(posedge clk) begin
      if (rst) begin
        flags_q[g] <= 1'b0;
      end else if (flag_we && upd_mask[g]) begin
        flags_q[g] <= nxt_flags[g];
      end
    end
  end

endmodule

// File: rtl/alu16_core.sv
module alu16_core
  import alu16_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         flag_we,
  input  logic         addi_mode,
  input  logic [3:0]   op_sel,
  input  logic [W-1:0] opnd_a,
  input  logic [W-1:0] opnd_b,
  output logic [W-1:0] result,
  output logic [3:0]   flags_q
);

  logic [3:0] eff_op;
  flag_vec_t  upd_mask;
  flag_vec_t  nxt_flags;
  logic       op_valid;

  alu16_mask_dec u_dec (
    .op_sel    (op_sel),
    .addi_mode (addi_mode),
    .eff_op    (eff_op),
    .upd_mask  (upd_mask),
    .op_valid  (op_valid)
  );

  alu16_datapath #(.W(W)) u_dp (
    .eff_op    (eff_op),
    .opnd_a    (opnd_a),
    .opnd_b    (opnd_b),
    .carry_in  (flags_q[FLG_C]),
    .result    (result),
    .nxt_flags (nxt_flags)
  );

  alu16_flag_reg u_flags (
    .clk       (clk),
    .rst       (rst),
    .flag_we   (flag_we),
    .upd_mask  (upd_mask),
    .nxt_flags (nxt_flags),
    .flags_q   (flags_q)
  );

endmodule

// File: rtl/alu16_checker.sv
module alu16_checker
  import alu16_pkg::*;
#(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst,
  input logic         flag_we,
  input logic         addi_mode,
  input logic [3:0]   op_sel,
  input logic [W-1:0] result,
  input logic [3:0]   flags_q,
  input logic [3:0]   upd_mask,
  input logic         op_valid
);

  logic unused_op;
  logic nz_only;
  assign unused_op = !addi_mode && (op_sel >= 4'd12);
  assign nz_only   = !addi_mode && (op_sel == OP_AND || op_sel == OP_OR || op_sel == OP_XOR ||
                                    op_sel == OP_NOT || op_sel == OP_ROL || op_sel == OP_ROR);

  assert_reset_clear_R1: assert property (@(posedge clk) rst |=> flags_q == 4'b0000);

  assert_hold_when_off_R2: assert property (@(posedge clk) disable iff (rst)
    !flag_we |=> $stable(flags_q));

  assert_unused_zero_R8: assert property (@(posedge clk) disable iff (rst)
    unused_op |-> (result == '0) && !op_valid);

  assert_unused_keeps_R8: assert property (@(posedge clk) disable iff (rst)
    unused_op |=> $stable(flags_q));

  assert_nz_only_keeps_co_R3: assert property (@(posedge clk) disable iff (rst)
    nz_only |=> $stable(flags_q[FLG_C]) && $stable(flags_q[FLG_O]));

  assert_zero_tracks_R5: assert property (@(posedge clk) disable iff (rst)
    (flag_we && upd_mask[FLG_Z]) |=> flags_q[FLG_Z] == ($past(result) == '0));

  assert_neg_tracks_R5: assert property (@(posedge clk) disable iff (rst)
    (flag_we && upd_mask[FLG_N]) |=> flags_q[FLG_N] == $past(result[W-1]));

  assert_addi_full_mask_R9: assert property (@(posedge clk) disable iff (rst)
    addi_mode |-> upd_mask == 4'hF);

endmodule

bind alu16_core alu16_checker #(.W(W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .flag_we   (flag_we),
  .addi_mode (addi_mode),
  .op_sel    (op_sel),
  .result    (result),
  .flags_q   (flags_q),
  .upd_mask  (upd_mask),
  .op_valid  (op_valid)
);

// File: tb/alu16_core_tb_top.sv
`timescale 1ns/1ps
module alu16_core_tb_top;

  logic        clk = 1'b0;
  logic        rst;
  logic        flag_we;
  logic        addi_mode;
  logic [3:0]  op_sel;
  logic [15:0] opnd_a;
  logic [15:0] opnd_b;
  logic [15:0] result;
  logic [3:0]  flags_q;

  int n_checks = 0;
  int n_fails  = 0;
  bit done     = 1'b0;

  always #2.5 clk = ~clk;

  alu16_core dut_i (
    .clk(clk), .rst(rst), .flag_we(flag_we), .addi_mode(addi_mode),
    .op_sel(op_sel), .opnd_a(opnd_a), .opnd_b(opnd_b),
    .result(result), .flags_q(flags_q)
  );

  // {addi, op, a, b, we, expected result, expected flags {O,C,N,Z}}
  // Entries chain: each starts from the flags left by the previous one.
  localparam int NV = 22;
  localparam logic [57:0] VEC [NV] = '{
    {1'b0, 4'd4,  16'hFFFF, 16'h0001, 1'b1, 16'h0000, 4'b0101},
    {1'b0, 4'd8,  16'h0001, 16'h0001, 1'b1, 16'h0003, 4'b0000},
    {1'b0, 4'd4,  16'h7FFF, 16'h0001, 1'b1, 16'h8000, 4'b1010},
    {1'b0, 4'd0,  16'hF0F0, 16'h0FF0, 1'b1, 16'h00F0, 4'b1000},
    {1'b0, 4'd5,  16'h0001, 16'h0002, 1'b1, 16'hFFFF, 4'b0110},
    {1'b0, 4'd9,  16'h0005, 16'h0003, 1'b1, 16'h0001, 4'b0000},
    {1'b0, 4'd5,  16'h8000, 16'h0001, 1'b1, 16'h7FFF, 4'b1000},
    {1'b0, 4'd2,  16'h8001, 16'h0000, 1'b1, 16'h0002, 4'b1100},
    {1'b0, 4'd10, 16'h4000, 16'h0000, 1'b1, 16'h8001, 4'b1110},
    {1'b0, 4'd3,  16'h0001, 16'h0000, 1'b1, 16'h0000, 4'b1101},
    {1'b0, 4'd11, 16'h0000, 16'h0000, 1'b1, 16'h8000, 4'b1110},
    {1'b0, 4'd6,  16'hAAAA, 16'hAAAA, 1'b1, 16'h0000, 4'b1101},
    {1'b0, 4'd7,  16'h00FF, 16'h1234, 1'b1, 16'hFF00, 4'b1110},
    {1'b0, 4'd1,  16'h0000, 16'h0000, 1'b1, 16'h0000, 4'b1101},
    {1'b1, 4'd0,  16'h0005, 16'hFFFF, 1'b1, 16'h0004, 4'b0100},
    {1'b0, 4'd8,  16'hFFFF, 16'h0000, 1'b1, 16'h0000, 4'b0101},
    {1'b0, 4'd9,  16'h0000, 16'h0000, 1'b1, 16'hFFFF, 4'b0110},
    {1'b0, 4'd12, 16'h1234, 16'h5678, 1'b1, 16'h0000, 4'b0110},
    {1'b0, 4'd4,  16'h0001, 16'h0001, 1'b0, 16'h0002, 4'b0110},
    {1'b0, 4'd11, 16'h0002, 16'h0000, 1'b1, 16'h8001, 4'b0110},
    {1'b0, 4'd10, 16'h8000, 16'h0000, 1'b1, 16'h0001, 4'b0100},
    {1'b0, 4'd4,  16'h8000, 16'h8000, 1'b1, 16'h0000, 4'b1101}
  };

  function automatic string tag_of(input logic addi, input logic [3:0] op, input logic we);
    if (!we)  return "R2";
    if (addi) return "R9";
    case (op)
      4'd0, 4'd1, 4'd6, 4'd7: return "R3";
      4'd2, 4'd3:             return "R4";
      4'd4, 4'd5:             return "R5";
      4'd8, 4'd9:             return "R6";
      4'd10, 4'd11:           return "R7";
      default:                return "R8";
    endcase
  endfunction

  task automatic check(input string tag, input string what, input logic [15:0] act,
                       input logic [15:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic run(input logic addi, input logic [3:0] op, input logic [15:0] a,
                     input logic [15:0] b, input logic we, input logic [15:0] exp_res,
                     input logic [3:0] exp_flg, input string tag);
    @(negedge clk);
    addi_mode = addi; op_sel = op; opnd_a = a; opnd_b = b; flag_we = we;
    #1;
    check(tag, "result", result, exp_res);
    @(posedge clk);
    #1;
    check(tag, "flags", {12'h0, flags_q}, {12'h0, exp_flg});
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
  endtask

  initial begin
    rst = 1'b1; flag_we = 1'b1; addi_mode = 1'b0; op_sel = 4'd4;
    opnd_a = 16'hFFFF; opnd_b = 16'h0001;
    repeat (3) @(posedge clk);
    #1;
    check("R1", "flags after reset", {12'h0, flags_q}, 16'h0000);
    @(negedge clk);
    rst = 1'b0; flag_we = 1'b0;

    for (int i = 0; i < NV; i++) begin
      run(VEC[i][57], VEC[i][56:53], VEC[i][52:37], VEC[i][36:21], VEC[i][20],
          VEC[i][19:4], VEC[i][3:0], tag_of(VEC[i][57], VEC[i][56:53], VEC[i][20]));
    end

    // R1: reset wins over an enabled update that would set flags
    @(negedge clk);
    rst = 1'b1; flag_we = 1'b1; addi_mode = 1'b0; op_sel = 4'd4;
    opnd_a = 16'h8000; opnd_b = 16'h8000;
    @(posedge clk);
    #1;
    check("R1", "reset over enable", {12'h0, flags_q}, 16'h0000);
    @(negedge clk);
    rst = 1'b0;

    // R8: unused codes keep set flags and yield zero
    run(1'b0, 4'd4, 16'hFFFF, 16'h0001, 1'b1, 16'h0000, 4'b0101, "R5");
    run(1'b0, 4'd13, 16'hFFFF, 16'hFFFF, 1'b1, 16'h0000, 4'b0101, "R8");
    run(1'b0, 4'd15, 16'h8000, 16'h0001, 1'b1, 16'h0000, 4'b0101, "R8");
    // R2: shift with enable low leaves flags
    run(1'b0, 4'd2, 16'h8000, 16'h0000, 1'b0, 16'h0000, 4'b0101, "R2");
    // R5: plain add ignores the set carry
    run(1'b0, 4'd4, 16'h0001, 16'h0001, 1'b1, 16'h0002, 4'b0000, "R5");
    // R9: add-immediate with negative immediate reaching zero and op code ignored
    run(1'b1, 4'd15, 16'h0001, 16'hFFFF, 1'b1, 16'h0000, 4'b0101, "R9");
    // R6: add-with-carry uses carry, subtract-with-borrow without borrow
    run(1'b0, 4'd8, 16'h7FFF, 16'h0000, 1'b1, 16'h8000, 4'b1010, "R6");
    run(1'b0, 4'd9, 16'h0003, 16'h0003, 1'b1, 16'h0000, 4'b0001, "R6");

    done = 1'b1;
    summary();
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fails++;
      $display("FAIL R1 watchdog: actual running expected finished");
      summary();
      $finish;
    end
  end

endmodule